// File: doc/BRIEF.md
# Dual-Group Status Interrupt Controller

This block watches two bytes of status conditions and merges them into one active-low interrupt line. The first byte holds charger conditions. They are treated as levels, and four of them latch, so software can clear them to restart the charger. The second byte holds regulator conditions. These raise a request only when a bit rises while it is unmasked.

Each group has a mask byte that resets to all ones. Each group also has a hidden acknowledge byte. A bus read of a status byte acknowledges the pending bits of that group. This lets the interrupt line fall back high, or stay low for the next pending condition. An acknowledge bit drops by itself once its condition goes away.

A plain byte-wide register port, with a select, a write enable, a 3-bit address and read data that is valid in the same cycle, gives access at fixed addresses. The address map is: charger status 1, regulator status 2, charger mask 3, regulator mask 4, charger acknowledge 5, regulator acknowledge 6. All inputs are synchronous to `clk`.

Top module: `status_irq_ctl`

## Requirements
- R1: `irq_n` is a register. It goes low on the clock edge after any unmasked, unacknowledged request is pending, and it is high whenever none is pending.
- R2: Both mask bytes reset to FFh, so `irq_n` stays high after reset whatever the inputs do. Writing address 3 or 4 loads the charger or regulator mask, which reads back at the same address. A mask bit of 1 blocks its condition.
- R3: A charger status bit at 1, with mask 0 and acknowledge 0, is a pending request for as long as it stays 1.
- R4: A regulator request is armed only by a 0-to-1 change of its status bit while the mask bit is 0. A bit that is already high when it is unmasked raises no request. An armed request is released when the bit falls.
- R5: A read of address 1 or 2 sets the acknowledge bit of every bit of that group that is pending and unmasked, one edge later. This releases `irq_n` on the following edge if nothing else is pending. Addresses 5 and 6 read the acknowledge bytes, and bus writes to them are ignored.
- R6: An acknowledge bit clears itself on the edge after its status bit reads 0.
- R7: Charger status bits 4..1 latch a high input. A write to address 1 clears every bit among 4..1 that is written as 0 (unless its input is high). Such a write also drives `chg_reset` high for exactly the cycle after the write edge. Written 1s in bits 4..1 and all writes to bits 0 and 7..5 leave the status unchanged. Bits 0 and 7..5 follow their inputs one edge late.
- R8: Regulator status bit 4 is not implemented and always reads 0. Writes to address 2 are ignored.
- R9: After reset the status and acknowledge bytes read 00h, `chg_reset` is 0, and addresses 0 and 7 read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_in | input | 8 | Charger condition inputs |
| reg_in | input | 8 | Regulator condition inputs |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt |
| chg_reset | output | 1 | One-cycle charger restart pulse |

## Verification
The bench aims at a regulator bit that is already high when it is unmasked. A design that treats the regulator group as levels would pull `irq_n` low there. It also checks that acknowledge bits clear themselves once a condition falls; a design that keeps them stuck would silently swallow the next occurrence. Writes of 1s and writes of 0s to the latched charger bits are both tried. A wrong design would either wipe flags it should keep or pulse `chg_reset` on a harmless write. Random traffic then compares every interrupt, pulse and read value with a cycle model, which also catches an interrupt that is off by one cycle.

// File: rtl/status_irq_pkg.sv
package status_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CHG_STAT = 3'd1;
  localparam logic [AW-1:0] A_REG_STAT = 3'd2;
  localparam logic [AW-1:0] A_CHG_MASK = 3'd3;
  localparam logic [AW-1:0] A_REG_MASK = 3'd4;
  localparam logic [AW-1:0] A_CHG_ACK  = 3'd5;
  localparam logic [AW-1:0] A_REG_ACK  = 3'd6;
  localparam logic [DW-1:0] CHG_LATCH_BITS = 8'h1E;
  localparam logic [DW-1:0] REG_IMPL_BITS  = 8'hEF;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 8,
  parameter bit EDGE = 1'b0,
  parameter logic [W-1:0] LATCH_BITS = '0,
  parameter logic [W-1:0] IMPL_BITS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic         rd_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic [W-1:0] ack,
  output logic [W-1:0] src
);
  logic [W-1:0] stat_q, mask_q, ack_q, req, keep, stat_d;

  assign keep   = wr_stat ? wdata : '1;
  assign stat_d = ((stat_q & LATCH_BITS & keep) | cond) & IMPL_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      ack_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_mask) mask_q <= wdata;
      ack_q <= (ack_q | (rd_stat ? (req & ~mask_q) : '0)) & stat_q;
    end
  end

  generate
    if (EDGE) begin : g_edge
      logic [W-1:0] arm_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= (arm_q & stat_d) | (stat_d & ~stat_q & ~mask_q);
      end
      assign req = arm_q;

      p_arm_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((arm_q & ~$past(arm_q)) & ~(stat_q & ~$past(stat_q))) == '0);
    end else begin : g_level
      assign req = stat_q;
    end
  endgenerate

  assign src  = req & ~mask_q & ~ack_q;
  assign stat = stat_q;
  assign mask = mask_q;
  assign ack  = ack_q;

  p_ack_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q & ~$past(stat_q)) == '0);

  p_ack_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_q & ~$past(ack_q)) != '0) |-> $past(rd_stat));

  p_follow_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~LATCH_BITS) == $past(cond & IMPL_BITS & ~LATCH_BITS));
endmodule

// File: rtl/status_irq_ctl.sv
module status_irq_ctl
  import status_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] chg_in,
  input  logic [DW-1:0] reg_in,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n,
  output logic          chg_reset
);
  logic wr, rd;
  logic [DW-1:0] c_stat, c_mask, c_ack, c_src;
  logic [DW-1:0] r_stat, r_mask, r_ack, r_src;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  irq_group #(.W(DW), .EDGE(1'b0), .LATCH_BITS(CHG_LATCH_BITS), .IMPL_BITS('1)) u_chg (
    .clk(clk), .rst_n(rst_n), .cond(chg_in),
    .wr_stat(wr && bus_addr == A_CHG_STAT),
    .wr_mask(wr && bus_addr == A_CHG_MASK),
    .rd_stat(rd && bus_addr == A_CHG_STAT),
    .wdata(bus_wdata),
    .stat(c_stat), .mask(c_mask), .ack(c_ack), .src(c_src));

  irq_group #(.W(DW), .EDGE(1'b1), .LATCH_BITS('0), .IMPL_BITS(REG_IMPL_BITS)) u_reg (
    .clk(clk), .rst_n(rst_n), .cond(reg_in),
    .wr_stat(1'b0),
    .wr_mask(wr && bus_addr == A_REG_MASK),
    .rd_stat(rd && bus_addr == A_REG_STAT),
    .wdata(bus_wdata),
    .stat(r_stat), .mask(r_mask), .ack(r_ack), .src(r_src));

  always_comb begin
    case (bus_addr)
      A_CHG_STAT: bus_rdata = c_stat;
      A_REG_STAT: bus_rdata = r_stat;
      A_CHG_MASK: bus_rdata = c_mask;
      A_REG_MASK: bus_rdata = r_mask;
      A_CHG_ACK:  bus_rdata = c_ack;
      A_REG_ACK:  bus_rdata = r_ack;
      default:    bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n     <= 1'b1;
      chg_reset <= 1'b0;
    end else begin
      irq_n     <= ~|(c_src | r_src);
      chg_reset <= wr && bus_addr == A_CHG_STAT &&
                   ((bus_wdata & CHG_LATCH_BITS) != CHG_LATCH_BITS);
    end
  end

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&c_mask && &r_mask) |=> irq_n);

  p_pulse_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_reset |-> $past(wr && bus_addr == A_CHG_STAT));

  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_REG_STAT) |-> !bus_rdata[4]);
endmodule

// File: tb/test_status_irq_ctl.sv
module test_status_irq_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] chg_in = '0, reg_in = '0, bus_wdata = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_rdata;
  logic irq_n, chg_reset;

  int total = 0, bad = 0;
  logic [7:0] last_rd;

  // reference model state
  logic [7:0] m_s1, m_m1, m_a1, m_s2, m_m2, m_a2, m_e2;
  logic m_irq, m_rst;

  always #10 clk = ~clk;

  status_irq_ctl i_status_irq_ctl (
    .clk(clk), .rst_n(rst_n), .chg_in(chg_in), .reg_in(reg_in),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .chg_reset(chg_reset));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd1: return m_s1;
      3'd2: return m_s2;
      3'd3: return m_m1;
      3'd4: return m_m2;
      3'd5: return m_a1;
      3'd6: return m_a2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd1: return "R3";
      3'd2: return "R8";
      3'd3, 3'd4: return "R2";
      3'd5, 3'd6: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_a1 = 0; m_a2 = 0; m_e2 = 0;
    m_m1 = 8'hFF; m_m2 = 8'hFF; m_irq = 1; m_rst = 0;
  endtask

  task automatic model_step(input logic sel, input logic we, input logic [2:0] a, input logic [7:0] wd);
    logic [7:0] src1, src2, keep, n_s1, n_s2, n_e2;
    logic wr, rd;
    wr = sel & we; rd = sel & ~we;
    src1 = m_s1 & ~m_m1 & ~m_a1;
    src2 = m_e2 & ~m_m2 & ~m_a2;
    keep = (wr && a == 3'd1) ? wd : 8'hFF;
    n_s1 = (m_s1 & 8'h1E & keep) | chg_in;
    n_s2 = reg_in & 8'hEF;
    n_e2 = (m_e2 & n_s2) | (n_s2 & ~m_s2 & ~m_m2);
    m_a1 = (m_a1 | ((rd && a == 3'd1) ? (m_s1 & ~m_m1) : 8'h00)) & m_s1;
    m_a2 = (m_a2 | ((rd && a == 3'd2) ? (m_e2 & ~m_m2) : 8'h00)) & m_s2;
    m_irq = ~|(src1 | src2);
    m_rst = wr && a == 3'd1 && ((wd & 8'h1E) != 8'h1E);
    if (wr && a == 3'd3) m_m1 = wd;
    if (wr && a == 3'd4) m_m2 = wd;
    m_s1 = n_s1; m_s2 = n_s2; m_e2 = n_e2;
  endtask

  // one clock: drive at negedge, sample read data mid-low phase, update model at posedge
  task automatic tick(input logic sel, input logic we, input logic [2:0] a, input logic [7:0] wd);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    #5;
    last_rd = bus_rdata;
    if (sel && !we) chk(read_tag(a), bus_rdata, model_read(a));
    @(posedge clk);
    model_step(sel, we, a, wd);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R1 irq_n", {7'd0, irq_n}, {7'd0, m_irq});
    chk("R7 chg_reset", {7'd0, chg_reset}, {7'd0, m_rst});
  endtask

  task automatic idle(); tick(1'b0, 1'b0, 3'd0, 8'h00); endtask
  task automatic rd(input logic [2:0] a); tick(1'b1, 1'b0, a, 8'h00); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); tick(1'b1, 1'b1, a, d); endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R2 irq_n in reset", {7'd0, irq_n}, 8'h01);
    chk("R9 chg_reset in reset", {7'd0, chg_reset}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd3); chk("R2 mask1 reset", last_rd, 8'hFF);
    rd(3'd4); chk("R2 mask2 reset", last_rd, 8'hFF);
    rd(3'd1); chk("R9 stat1 reset", last_rd, 8'h00);
    rd(3'd6); chk("R9 ack2 reset", last_rd, 8'h00);
    rd(3'd7); chk("R9 unused addr", last_rd, 8'h00);

    // R2/R3: masked level, then unmasked
    chg_in = 8'h80; idle(); idle();
    chk("R2 masked keeps irq high", {7'd0, irq_n}, 8'h01);
    wr(3'd3, 8'h7F); idle();
    chk("R3 level request", {7'd0, irq_n}, 8'h00);
    // R5: read acknowledges
    rd(3'd1); chk("R3 stat1 read", last_rd, 8'h80);
    idle();
    chk("R5 irq released after ack", {7'd0, irq_n}, 8'h01);
    rd(3'd5); chk("R5 ack1 set", last_rd, 8'h80);
    wr(3'd5, 8'h00); rd(3'd5); chk("R5 ack write ignored", last_rd, 8'h80);
    // R6: self clear
    chg_in = 8'h00; idle(); idle();
    rd(3'd5); chk("R6 ack1 cleared", last_rd, 8'h00);

    // R4: already-high bit unmasked gives no request
    reg_in = 8'h01; idle();
    wr(3'd4, 8'hFE); idle(); idle();
    chk("R4 no request without rise", {7'd0, irq_n}, 8'h01);
    reg_in = 8'h00; idle();
    reg_in = 8'h01; idle(); idle();
    chk("R4 rise arms request", {7'd0, irq_n}, 8'h00);
    rd(3'd2); idle();
    chk("R5 regulator ack releases", {7'd0, irq_n}, 8'h01);
    reg_in = 8'h00; idle(); idle();
    rd(3'd6); chk("R6 ack2 cleared", last_rd, 8'h00);

    // R7: latched bits and charger reset pulse
    chg_in = 8'h04; idle(); chg_in = 8'h00; idle();
    rd(3'd1); chk("R7 bit2 latched", last_rd, 8'h04);
    wr(3'd1, 8'hFF);
    chk("R7 no pulse on all-ones write", {7'd0, chg_reset}, 8'h00);
    rd(3'd1); chk("R7 ones keep bit", last_rd, 8'h04);
    wr(3'd1, 8'h00);
    chk("R7 pulse on zero write", {7'd0, chg_reset}, 8'h01);
    idle();
    chk("R7 pulse one cycle", {7'd0, chg_reset}, 8'h00);
    rd(3'd1); chk("R7 bit cleared", last_rd, 8'h00);
    wr(3'd1, 8'hE1); rd(3'd1); chk("R7 read-only bits ignore write", last_rd, 8'h00);

    // R8
    reg_in = 8'hFF; idle();
    rd(3'd2); chk("R8 bit4 reads zero", last_rd, 8'hEF);
    wr(3'd2, 8'h00); rd(3'd2); chk("R8 write to stat2 ignored", last_rd, 8'hEF);

    // random traffic against the model
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd1234);
      for (int i = 0; i < 600; i++) begin
        int unsigned r;
        r = $urandom;
        if (r[3:0] == 4'd0) chg_in = chg_in ^ (8'h01 << r[6:4]);
        if (r[10:8] == 3'd0) reg_in = reg_in ^ (8'h01 << r[14:12]);
        if (r[17:16] != 2'd0)
          tick(1'b1, r[18], r[21:19], r[29:22]);
        else
          idle();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule